// File: doc/BRIEF.md
# Cluster Operand and Write-Back Steering Fabric

This block is the data-steering fabric that sits between four processing elements, the input memory and two scratchpad memories. Four shared operand buses each pick one word from five candidate sources: the two input-memory read ports, the read port of each scratchpad, and an immediate carried in the control word. The buses are seen by every element.

Each element places one outgoing word per cycle on its point-to-point links. The fabric wires every element to the other three, so each element receives three link words. The same outgoing words feed four write-back multiplexers, one per scratchpad write port. Each multiplexer picks one of two elements, and each multiplexer has its own write-enable bit.

The fabric is purely combinational and holds no state. All selects come from control-word fields applied in the same cycle, and operands are registered by whichever element consumes them.

Top module: `cluster_xbar`

## Requirements
- R1: Each bus has its own 3-bit select field, and bus b uses bits [3b+2:3b] of `bus_sel`. Code 0 puts input port A on the bus. Code 1 puts input port B on it. Code 2 selects the scratchpad 0 read word, code 3 the scratchpad 1 read word, and code 4 the immediate.
- R2: Select codes 5, 6 and 7 drive all-zero onto the bus, whatever the sources carry.
- R3: The four buses are independent. A select field changes only its own bus, and all four buses may carry the same source at once.
- R4: Element i receives three link words in slots 0..2. Slot s carries the outgoing word of element (i+s+1) mod 4.
- R5: Write port p takes element p's word when `wb_sel[p]` is 0 and element (p+2) mod 4's word when it is 1. Ports 0 and 1 belong to scratchpad 0, and ports 2 and 3 belong to scratchpad 1, so every element can reach both scratchpads.
- R6: When `wb_en[p]` is 0, port p's write strobe is low and its write data is all-zero. When `wb_en[p]` is 1, the strobe is high.
- R7: All outputs follow their inputs within the same cycle. No clock edge is needed and no earlier input affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_rd_a | input | 16 | Input memory read port A |
| in_rd_b | input | 16 | Input memory read port B |
| sp0_rd | input | 16 | Scratchpad 0 read word |
| sp1_rd | input | 16 | Scratchpad 1 read word |
| imm | input | 16 | Control-word immediate |
| bus_sel | input | 12 | Four 3-bit bus source selects |
| pe_tx | input | 64 | Outgoing word of each element, element e at [16e+15:16e] |
| wb_sel | input | 4 | Per write port element choice |
| wb_en | input | 4 | Per write port enable |
| bus | output | 64 | Four shared buses, bus b at [16b+15:16b] |
| pe_link_in | output | 192 | Link words, element i slot s at index 3i+s |
| sp_wdata | output | 64 | Write data for the four scratchpad ports |
| sp_we | output | 4 | Write strobes for the four scratchpad ports |

## Verification
The bench drives the unused select codes 5 to 7 while every source carries a non-zero word. A fabric that decoded only the low bits would alias these codes onto a real source. It also gives each bus a different code in the same cycle, which catches swapped or shared select fields. Swapped field slices would put the wrong source on a bus.

Write ports are tested with the enable cleared while the chosen element has data. A design that gated only the strobe would leak that data onto the write bus. Both element choices are tested on each port, so a wrong pairing shows up as the wrong element's word. The link slots are checked against their rotation, which exposes an off-by-one in the wiring. Inputs are also changed mid-cycle with no clock edge, which catches a design that registers its outputs.

// File: rtl/cluster_xbar.sv
`timescale 1ns/1ps
module cluster_xbar #(
  parameter int DW = 16,
  localparam int NPE = 4,
  localparam int NBUS = 4,
  localparam int NPORT = 4,
  localparam int NLINK = NPE - 1,
  localparam int SELW = 3
) (
  input  logic [DW-1:0]             in_rd_a,
  input  logic [DW-1:0]             in_rd_b,
  input  logic [DW-1:0]             sp0_rd,
  input  logic [DW-1:0]             sp1_rd,
  input  logic [DW-1:0]             imm,
  input  logic [NBUS*SELW-1:0]      bus_sel,
  input  logic [NPE*DW-1:0]         pe_tx,
  input  logic [NPORT-1:0]          wb_sel,
  input  logic [NPORT-1:0]          wb_en,
  output logic [NBUS*DW-1:0]        bus,
  output logic [NPE*NLINK*DW-1:0]   pe_link_in,
  output logic [NPORT*DW-1:0]       sp_wdata,
  output logic [NPORT-1:0]          sp_we
);

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic [SELW-1:0] sel;
    logic [DW-1:0]   val;
    assign sel = bus_sel[b*SELW +: SELW];
    always_comb begin
      case (sel)
        3'd0:    val = in_rd_a;
        3'd1:    val = in_rd_b;
        3'd2:    val = sp0_rd;
        3'd3:    val = sp1_rd;
        3'd4:    val = imm;
        default: val = '0;
      endcase
    end
    assign bus[b*DW +: DW] = val;
  end

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    for (genvar s = 0; s < NLINK; s++) begin : g_slot
      localparam int SRC = (i + s + 1) % NPE;
      assign pe_link_in[(i*NLINK+s)*DW +: DW] = pe_tx[SRC*DW +: DW];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int ALT = (p + 2) % NPE;
    logic [DW-1:0] pick;
    assign pick = wb_sel[p] ? pe_tx[ALT*DW +: DW] : pe_tx[p*DW +: DW];
    assign sp_wdata[p*DW +: DW] = wb_en[p] ? pick : '0;
    assign sp_we[p] = wb_en[p];
  end

endmodule

// File: rtl/cluster_xbar_chk.sv
`timescale 1ns/1ps
module cluster_xbar_chk #(
  parameter int DW = 16
) (
  input logic [DW-1:0]     in_rd_a,
  input logic [DW-1:0]     in_rd_b,
  input logic [DW-1:0]     sp0_rd,
  input logic [DW-1:0]     sp1_rd,
  input logic [DW-1:0]     imm,
  input logic [11:0]       bus_sel,
  input logic [4*DW-1:0]   pe_tx,
  input logic [3:0]        wb_en,
  input logic [4*DW-1:0]   bus,
  input logic [12*DW-1:0]  pe_link_in,
  input logic [4*DW-1:0]   sp_wdata,
  input logic [3:0]        sp_we
);

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      if (bus_sel[b*3 +: 3] > 3'd4)
        p_unused_code_zero_r2: assert (bus[b*DW +: DW] == '0);
      if (bus_sel[b*3 +: 3] == 3'd4)
        p_imm_on_bus_r1: assert (bus[b*DW +: DW] == imm);
      if (bus[b*DW +: DW] != '0)
        p_bus_has_source_r1: assert (bus[b*DW +: DW] == in_rd_a || bus[b*DW +: DW] == in_rd_b ||
                                     bus[b*DW +: DW] == sp0_rd  || bus[b*DW +: DW] == sp1_rd  ||
                                     bus[b*DW +: DW] == imm);
    end
    for (int i = 0; i < 4; i++)
      p_link_symmetry_r4: assert (pe_link_in[(i*3+0)*DW +: DW] ==
                                  pe_link_in[(((i+2)%4)*3+2)*DW +: DW]);
    for (int p = 0; p < 4; p++) begin
      if (!wb_en[p])
        p_disabled_port_quiet_r6: assert (!sp_we[p] && sp_wdata[p*DW +: DW] == '0);
      if (sp_we[p])
        p_port_pair_r5: assert (sp_wdata[p*DW +: DW] == pe_tx[p*DW +: DW] ||
                                sp_wdata[p*DW +: DW] == pe_tx[((p+2)%4)*DW +: DW]);
    end
  end

endmodule

bind cluster_xbar cluster_xbar_chk #(.DW(DW)) u_chk (
  .in_rd_a(in_rd_a), .in_rd_b(in_rd_b), .sp0_rd(sp0_rd), .sp1_rd(sp1_rd),
  .imm(imm), .bus_sel(bus_sel), .pe_tx(pe_tx), .wb_en(wb_en),
  .bus(bus), .pe_link_in(pe_link_in), .sp_wdata(sp_wdata), .sp_we(sp_we)
);

// File: tb/tb_cluster_xbar.sv
`timescale 1ns/1ps
module tb_cluster_xbar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0]  in_rd_a, in_rd_b, sp0_rd, sp1_rd, imm;
  logic [11:0]  bus_sel;
  logic [63:0]  pe_tx;
  logic [3:0]   wb_sel, wb_en;
  logic [63:0]  bus;
  logic [191:0] pe_link_in;
  logic [63:0]  sp_wdata;
  logic [3:0]   sp_we;

  cluster_xbar dut (
    .in_rd_a(in_rd_a), .in_rd_b(in_rd_b), .sp0_rd(sp0_rd), .sp1_rd(sp1_rd),
    .imm(imm), .bus_sel(bus_sel), .pe_tx(pe_tx), .wb_sel(wb_sel), .wb_en(wb_en),
    .bus(bus), .pe_link_in(pe_link_in), .sp_wdata(sp_wdata), .sp_we(sp_we)
  );

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [19:0] VEC [8] = '{
    {12'h053, 4'h0, 4'hF}, {12'h8D1, 4'hF, 4'hF},
    {12'h924, 4'h5, 4'hA}, {12'h000, 4'hA, 4'h5},
    {12'hBB8, 4'h3, 4'hC}, {12'hFFF, 4'hC, 4'h3},
    {12'h49B, 4'h9, 4'h0}, {12'h226, 4'h6, 4'hF}
  };

  function automatic logic [15:0] bus_model(input logic [2:0] code);
    case (code)
      3'd0: return in_rd_a;
      3'd1: return in_rd_b;
      3'd2: return sp0_rd;
      3'd3: return sp1_rd;
      3'd4: return imm;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    for (int b = 0; b < 4; b++)
      chk("R1/R2/R3 bus", bus[b*16 +: 16], bus_model(bus_sel[b*3 +: 3]));
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 3; s++)
        chk("R4 link slot", pe_link_in[(i*3+s)*16 +: 16], pe_tx[((i+s+1)%4)*16 +: 16]);
    for (int p = 0; p < 4; p++) begin
      chk("R6 strobe", {15'h0, sp_we[p]}, {15'h0, wb_en[p]});
      chk("R5/R6 wdata", sp_wdata[p*16 +: 16],
          !wb_en[p] ? 16'h0 : (wb_sel[p] ? pe_tx[((p+2)%4)*16 +: 16] : pe_tx[p*16 +: 16]));
    end
  endtask

  task automatic load_data(input int v);
    in_rd_a = 16'hA100 + 16'(v);
    in_rd_b = 16'hB200 + 16'(v);
    sp0_rd  = 16'hC300 + 16'(v);
    sp1_rd  = 16'hD400 + 16'(v);
    imm     = 16'hE500 + 16'(v);
    for (int e = 0; e < 4; e++)
      pe_tx[e*16 +: 16] = 16'(16'h1000 * (e + 1) + 16'h10 * v);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    in_rd_a = '0; in_rd_b = '0; sp0_rd = '0; sp1_rd = '0; imm = '0;
    bus_sel = '0; pe_tx = '0; wb_sel = '0; wb_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 idle strobes", {12'h0, sp_we}, 16'h0);
    chk("R1 idle bus0", bus[15:0], 16'h0);
    chk("R6 idle wdata", sp_wdata[15:0] | sp_wdata[31:16] | sp_wdata[47:32] | sp_wdata[63:48], 16'h0);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      load_data(v);
      {bus_sel, wb_sel, wb_en} = VEC[v];
      #1;
      check_all();
    end

    // R2: unused codes with all-ones sources
    @(negedge clk);
    in_rd_a = 16'hFFFF; in_rd_b = 16'hFFFF; sp0_rd = 16'hFFFF; sp1_rd = 16'hFFFF; imm = 16'hFFFF;
    bus_sel = {3'd7, 3'd6, 3'd5, 3'd7};
    #1;
    for (int b = 0; b < 4; b++) chk("R2 unused code zero", bus[b*16 +: 16], 16'h0);

    // R3: one field changes only its own bus
    bus_sel = {3'd0, 3'd0, 3'd0, 3'd0};
    in_rd_a = 16'h1234;
    #1;
    bus_sel[5:3] = 3'd4;
    imm = 16'h5A5A;
    #1;
    chk("R3 bus0 untouched", bus[15:0], 16'h1234);
    chk("R3 bus1 changed", bus[31:16], 16'h5A5A);
    chk("R3 bus2 untouched", bus[47:32], 16'h1234);
    chk("R3 bus3 untouched", bus[63:48], 16'h1234);

    // R6: disabled ports hide the selected element
    pe_tx = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
    wb_en = 4'h0; wb_sel = 4'hF;
    #1;
    for (int p = 0; p < 4; p++) chk("R6 disabled wdata", sp_wdata[p*16 +: 16], 16'h0);
    chk("R6 disabled strobes", {12'h0, sp_we}, 16'h0);

    // R5: every element reaches both scratchpads
    wb_en = 4'hF; wb_sel = 4'h0;
    #1;
    chk("R5 sp0 port0 elem0", sp_wdata[15:0], 16'h1111);
    chk("R5 sp0 port1 elem1", sp_wdata[31:16], 16'h2222);
    chk("R5 sp1 port2 elem2", sp_wdata[47:32], 16'h3333);
    chk("R5 sp1 port3 elem3", sp_wdata[63:48], 16'h4444);
    wb_sel = 4'hF;
    #1;
    chk("R5 sp0 port0 elem2", sp_wdata[15:0], 16'h3333);
    chk("R5 sp0 port1 elem3", sp_wdata[31:16], 16'h4444);
    chk("R5 sp1 port2 elem0", sp_wdata[47:32], 16'h1111);
    chk("R5 sp1 port3 elem1", sp_wdata[63:48], 16'h2222);

    // R7: mid-cycle change with no clock edge
    @(posedge clk);
    #1;
    pe_tx[15:0] = 16'hBEEF;
    wb_sel[2] = 1'b1;
    #0.5;
    chk("R7 same-cycle wdata", sp_wdata[47:32], 16'hBEEF);
    chk("R7 same-cycle link", pe_link_in[(3*3+0)*16 +: 16], 16'hBEEF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule